// File: doc/BRIEF.md
# Dual PDM Microphone Receiver

This block takes a one-bit pulse-density stream from two microphones that share a single data wire and a single bit clock. Each microphone drives the wire during one phase of the bit clock. The receiver captures one bit on the rising edge and one bit on the falling edge of that clock. It steers the two captures into separate left and right shift registers. When both halves are full, it presents them together as one stereo word.

The bit clock and data pin are sampled by a faster system clock through a synchronizer. A word sits in a holding register with a valid flag until the consumer pulses a read strobe. If a fresh word completes while the previous one is still unread, the new word replaces the old one. A sticky overrun flag then records the loss until the consumer clears it.

Top module: `pdm_stereo_rx`

## Requirements
- R1: After reset, `valid_o` is 0, `ovr_o` is 0 and `word_o` is all zeros.
- R2: The bit sampled at a rising bit-clock edge belongs to the left channel, held in `word_o[15:0]`. The bit sampled at a falling edge belongs to the right channel, held in `word_o[31:16]`.
- R3: Within each half, bits shift in toward the most significant end, with the newest bit at bit 0. The first bit of a word therefore lands at bit 15 of its half.
- R4: A word completes on the 16th falling edge after the previous word, which means after 16 rising/falling pairs. `valid_o` then rises and `word_o` shows the new word.
- R5: A `rd_i` pulse while `valid_o` is 1 clears `valid_o`, and `word_o` keeps its value.
- R6: When a word completes while `valid_o` is 1 and no read happens in that cycle, `ovr_o` is set and `word_o` takes the new word.
- R7: `ovr_o` stays set until `clr_ovr_i` is pulsed. A pulse then clears it.
- R8: When `rd_i` is pulsed in the same cycle that a word completes, the old word counts as read. `ovr_o` stays 0, `valid_o` stays 1 and `word_o` shows the new word.
- R9: A `rd_i` pulse while `valid_o` is 0 changes neither `valid_o`, `ovr_o` nor `word_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, much faster than the bit clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| pdm_clk_i | input | 1 | Shared microphone bit clock |
| pdm_dat_i | input | 1 | Shared microphone data line |
| rd_i | input | 1 | Consumer read strobe, one cycle |
| clr_ovr_i | input | 1 | Clear strobe for the overrun flag |
| word_o | output | 32 | Stereo word: right half on top, left half below |
| valid_o | output | 1 | An unread word is held |
| ovr_o | output | 1 | Sticky flag: a completed word was lost |

## Verification
The hardest case to reach from the ports is a read strobe that lands exactly in the cycle a word completes (R8). The completion happens three system cycles after the last falling bit-clock edge, behind the synchronizer and the pack register. The bench drives every bit-clock edge on a falling system edge and counts the stages, so it can raise `rd_i` for that single cycle. Random left/right words, interleaved with directed all-ones and single-bit patterns, show the lane steering and bit order.

// File: rtl/pdm_rx_pkg.sv
package pdm_rx_pkg;
  localparam int unsigned WORD_W_DEF = 32;
  localparam int unsigned SYNC_DEF   = 2;
endpackage

// File: rtl/pdm_edge_sync.sv
module pdm_edge_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pclk_i,
  input  logic pdat_i,
  output logic rise_o,
  output logic fall_o,
  output logic bit_o
);
  logic [STAGES-1:0] clk_sr, dat_sr;
  logic              clk_prev;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      clk_sr   <= '0;
      dat_sr   <= '0;
      clk_prev <= 1'b0;
    end else begin
      clk_sr   <= {clk_sr[STAGES-2:0], pclk_i};
      dat_sr   <= {dat_sr[STAGES-2:0], pdat_i};
      clk_prev <= clk_sr[STAGES-1];
    end
  end

  assign rise_o = clk_sr[STAGES-1] & ~clk_prev;
  assign fall_o = ~clk_sr[STAGES-1] & clk_prev;
  assign bit_o  = dat_sr[STAGES-1];
endmodule

// File: rtl/pdm_lane_pack.sv
module pdm_lane_pack #(
  parameter int unsigned WORD_W = 32,
  localparam int unsigned HALF_W = WORD_W / 2,
  localparam int unsigned CNT_W  = $clog2(HALF_W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rise_i,
  input  logic              fall_i,
  input  logic              bit_i,
  output logic              done_o,
  output logic [WORD_W-1:0] word_o
);
  logic [HALF_W-1:0] left_sr, right_sr;
  logic [CNT_W-1:0]  pair_cnt;
  logic              last_pair;

  assign last_pair = (pair_cnt == CNT_W'(HALF_W - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      left_sr  <= '0;
      right_sr <= '0;
      pair_cnt <= '0;
      done_o   <= 1'b0;
      word_o   <= '0;
    end else begin
      done_o <= 1'b0;
      if (rise_i) left_sr <= {left_sr[HALF_W-2:0], bit_i};
      if (fall_i) begin
        right_sr <= {right_sr[HALF_W-2:0], bit_i};
        if (last_pair) begin
          pair_cnt <= '0;
          done_o   <= 1'b1;
          word_o   <= {right_sr[HALF_W-2:0], bit_i, left_sr};
        end else begin
          pair_cnt <= pair_cnt + 1'b1;
        end
      end
    end
  end

  // R4
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
endmodule

// File: rtl/pdm_word_hold.sv
module pdm_word_hold #(
  parameter int unsigned WORD_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              done_i,
  input  logic [WORD_W-1:0] word_i,
  input  logic              rd_i,
  input  logic              clr_ovr_i,
  output logic [WORD_W-1:0] word_o,
  output logic              valid_o,
  output logic              ovr_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      word_o  <= '0;
      valid_o <= 1'b0;
      ovr_o   <= 1'b0;
    end else begin
      if (done_i) begin
        word_o  <= word_i;
        valid_o <= 1'b1;
      end else if (rd_i) begin
        valid_o <= 1'b0;
      end
      // loss wins over a simultaneous clear
      if (done_i && valid_o && !rd_i) ovr_o <= 1'b1;
      else if (clr_ovr_i)             ovr_o <= 1'b0;
    end
  end

  // R6
  ovr_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i && valid_o && !rd_i |=> ovr_o);
  // R7
  ovr_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovr_o && !clr_ovr_i |=> ovr_o);
  // R5
  rd_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_i && valid_o && !done_i |=> !valid_o && $stable(word_o));
  // R8
  rd_same_cycle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i && rd_i && !clr_ovr_i |=> valid_o && (ovr_o == $past(ovr_o)));
  // R9
  rd_empty_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_i && !valid_o && !done_i |=> !valid_o && $stable(word_o));
endmodule

// File: rtl/pdm_stereo_rx.sv
module pdm_stereo_rx
  import pdm_rx_pkg::*;
#(
  parameter int unsigned WORD_W = WORD_W_DEF,
  parameter int unsigned SYNC_N = SYNC_DEF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pdm_clk_i,
  input  logic              pdm_dat_i,
  input  logic              rd_i,
  input  logic              clr_ovr_i,
  output logic [WORD_W-1:0] word_o,
  output logic              valid_o,
  output logic              ovr_o
);
  logic              rise, fall, smp_bit, done;
  logic [WORD_W-1:0] packed_word;

  pdm_edge_sync #(.STAGES(SYNC_N)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .pclk_i(pdm_clk_i), .pdat_i(pdm_dat_i),
    .rise_o(rise), .fall_o(fall), .bit_o(smp_bit)
  );

  pdm_lane_pack #(.WORD_W(WORD_W)) u_pack (
    .clk_i(clk_i), .rst_ni(rst_ni), .rise_i(rise), .fall_i(fall),
    .bit_i(smp_bit), .done_o(done), .word_o(packed_word)
  );

  pdm_word_hold #(.WORD_W(WORD_W)) u_hold (
    .clk_i(clk_i), .rst_ni(rst_ni), .done_i(done), .word_i(packed_word),
    .rd_i(rd_i), .clr_ovr_i(clr_ovr_i), .word_o(word_o),
    .valid_o(valid_o), .ovr_o(ovr_o)
  );
endmodule

// File: tb/tb_pdm_stereo_rx.sv
module tb_pdm_stereo_rx;
  logic        clk = 1'b0, rst_ni = 1'b0;
  logic        pdm_clk = 1'b0, pdm_dat = 1'b0, rd = 1'b0, clr_ovr = 1'b0;
  logic [31:0] word;
  logic        valid, ovr;
  int          checks = 0, failures = 0;

  always #2.5 clk = ~clk;

  pdm_stereo_rx dut (
    .clk_i(clk), .rst_ni(rst_ni), .pdm_clk_i(pdm_clk), .pdm_dat_i(pdm_dat),
    .rd_i(rd), .clr_ovr_i(clr_ovr), .word_o(word), .valid_o(valid), .ovr_o(ovr)
  );

  function automatic logic [31:0] expect_word(input logic [15:0] l, input logic [15:0] r);
    return {r, l};
  endfunction

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic pdm_edge(input logic d);
    @(negedge clk) pdm_dat = d;
    @(negedge clk) pdm_clk = ~pdm_clk;
    repeat (2) @(negedge clk);
  endtask

  // first bit sent lands at bit 15 of each half
  task automatic send_frame(input logic [15:0] l, input logic [15:0] r);
    for (int i = 15; i >= 0; i--) begin
      pdm_edge(l[i]);
      pdm_edge(r[i]);
    end
  endtask

  task automatic pulse_rd();
    @(negedge clk) rd = 1'b1;
    @(negedge clk) rd = 1'b0;
  endtask

  task automatic pulse_clr();
    @(negedge clk) clr_ovr = 1'b1;
    @(negedge clk) clr_ovr = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [15:0] l, r, l2, r2;
    void'($urandom(32'h5eed1));
    repeat (3) @(negedge clk);
    check("R1 valid", {31'b0, valid}, 32'd0);
    check("R1 ovr", {31'b0, ovr}, 32'd0);
    check("R1 word", word, 32'd0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk);

    // R2: lane steering
    send_frame(16'hFFFF, 16'h0000);
    repeat (3) @(negedge clk);
    check("R4 valid", {31'b0, valid}, 32'd1);
    check("R2 left lane", word, expect_word(16'hFFFF, 16'h0000));
    pulse_rd();
    check("R5 valid cleared", {31'b0, valid}, 32'd0);
    check("R5 word held", word, expect_word(16'hFFFF, 16'h0000));

    // R3: bit order
    send_frame(16'h8001, 16'h4000);
    repeat (3) @(negedge clk);
    check("R3 order", word, expect_word(16'h8001, 16'h4000));
    pulse_rd();

    // R9: read while empty
    pulse_rd();
    check("R9 valid", {31'b0, valid}, 32'd0);
    check("R9 ovr", {31'b0, ovr}, 32'd0);
    check("R9 word", word, expect_word(16'h8001, 16'h4000));

    // R2 R3 R4 R5 random frames
    for (int k = 0; k < 8; k++) begin
      l = 16'($urandom); r = 16'($urandom);
      send_frame(l, r);
      repeat (3) @(negedge clk);
      check("R4 valid rand", {31'b0, valid}, 32'd1);
      check("R2 R3 rand word", word, expect_word(l, r));
      pulse_rd();
      check("R5 rand cleared", {31'b0, valid}, 32'd0);
    end

    // R6 overrun, R7 sticky then clear
    l = 16'($urandom); r = 16'($urandom);
    l2 = 16'($urandom); r2 = 16'($urandom);
    send_frame(l, r);
    send_frame(l2, r2);
    repeat (3) @(negedge clk);
    check("R6 ovr set", {31'b0, ovr}, 32'd1);
    check("R6 overwrite", word, expect_word(l2, r2));
    repeat (20) @(negedge clk);
    check("R7 sticky", {31'b0, ovr}, 32'd1);
    pulse_clr();
    check("R7 cleared", {31'b0, ovr}, 32'd0);
    check("R7 valid kept", {31'b0, valid}, 32'd1);

    // R8: read in the completion cycle (third posedge after last edge)
    send_frame(16'hA5C3, 16'h3C5A);
    @(negedge clk) rd = 1'b1;
    @(negedge clk) rd = 1'b0;
    repeat (2) @(negedge clk);
    check("R8 no ovr", {31'b0, ovr}, 32'd0);
    check("R8 valid", {31'b0, valid}, 32'd1);
    check("R8 new word", word, expect_word(16'hA5C3, 16'h3C5A));

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule